// File: doc/BRIEF.md
# Programmable-Length SPI Shift Engine

This block is a single-lane SPI master that runs short, arbitrary flash commands whose length is set in bits rather than in whole bytes. Software fills a bank of six transmit byte registers, writes a bit count of up to 56, and then writes the control register with its start bit set. The engine pulls chip select low and clocks the requested number of bits out in SPI mode 0, most significant bit first. It takes the first byte from the highest-numbered transmit register and works down. While it shifts, every bit returned on MISO enters an 80-bit receive shift register that software reads back as ten bytes.

When the count is longer than the 48 bits the transmit bank holds, the extra clocks drive MOSI low. Those extra clocks cover dummy cycles and the bytes that come back from the flash. A stretch option in the control register adds one clock to a transfer, so returned data can be sampled later. The start bit reads back as set for as long as the transfer runs, so software can poll it. A one-cycle `done` pulse and a `busy` level give the same information to hardware.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sck` and `spi_mosi` are low, `busy` is low, and every register reads zero: transmit bytes, bit count, control and receive bytes.
- R2: The register map has transmit byte i at address i (0..5), the bit count at address 6, control at address 7 (start = bit 2, stretch = bit 4) and receive byte j at address 8+j (0..9). A bit count written above 56 is stored as 56.
- R3: Writing control with bit 2 set and a non-zero count lowers `spi_cs_n` and raises `busy` on the same clock edge. Control bit 2 reads 1 until the transfer ends, then reads 0. `done` pulses for one cycle on the edge where `spi_cs_n` returns high.
- R4: Bit k of a transfer (k = 0 first) is bit 7-(k mod 8) of transmit byte 5-(k div 8). The wire order is therefore byte 5, byte 4, down to byte 0, each sent MSB first.
- R5: For bit positions 48 and above, MOSI is driven 0.
- R6: SCK idles low and, with `cs_n` low, makes exactly N rising edges, where N is the effective bit count. Each half period lasts HALF_DIV clocks, so `spi_cs_n` stays low for N*2*HALF_DIV cycles.
- R7: When the start write also has bit 4 set, N is the stored count plus one. Without bit 4, N is the stored count.
- R8: The receive bank is one 80-bit shift register. MISO is sampled at each SCK rising edge and enters at bit 0 of receive byte 0, while older bits move toward byte 9. The bank is not cleared when a transfer starts.
- R9: A start with a stored count of zero produces `done` on the next edge, leaves `spi_cs_n` high and makes no SCK edge, even when stretch is set.
- R10: While `busy` is high, every register write is ignored. This covers a second start, a stretch change and transmit data.
- R11: MOSI changes only while SCK is low. It is driven on the falling edge and held for the whole high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A register write can arrive on the same clock edge as an SCK toggle or a bit advance in the middle of a transfer. The write could try to restart the engine, change stretch or overwrite the transmit byte being shifted. The bench provokes this by issuing a second start with stretch set, plus a new value for transmit byte 5, while a 16-bit transfer is shifting. It judges the outcome at the ports: exactly 16 SCK pulses, the original MOSI stream, unchanged readback of byte 5 and of the stretch bit, and no further activity afterwards.

// File: rtl/sse_pkg.sv
package sse_pkg;
    localparam int TX_BYTES     = 6;
    localparam int RX_BYTES     = 10;
    localparam int MAX_BITS     = 56;
    localparam int TX_BITS      = TX_BYTES * 8;
    localparam int RX_BITS      = RX_BYTES * 8;
    localparam int CNT_W        = $clog2(MAX_BITS + 2);
    localparam int ADDR_W       = 5;
    localparam int A_CNT        = TX_BYTES;
    localparam int A_CTRL       = TX_BYTES + 1;
    localparam int A_RX0        = TX_BYTES + 2;
    localparam int CTRL_START   = 2;
    localparam int CTRL_STRETCH = 4;

    typedef enum logic [0:0] {SH_IDLE, SH_RUN} sh_state_e;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic mosi;
    } spi_pins_t;

    // bit k of the outgoing stream; positions past the transmit bank read as 0
    function automatic logic stream_bit(logic [TX_BITS-1:0] flat, logic [CNT_W-1:0] k);
        if (int'(k) < TX_BITS) return flat[TX_BITS-1-int'(k)];
        return 1'b0;
    endfunction
endpackage

// File: rtl/sse_regbank.sv
module sse_regbank
    import sse_pkg::*;
#(
    parameter int NTX  = TX_BYTES,
    parameter int MAXB = MAX_BITS,
    parameter int CW   = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [NTX*8-1:0]  tx_flat,
    output logic [CW-1:0]     cnt_q,
    output logic              stretch_q
);
    logic [7:0] tx_q [NTX];

    for (genvar i = 0; i < NTX; i++) begin : g_tx
        always_ff @(posedge clk) begin
            if (rst)                                tx_q[i] <= '0;
            else if (wr_ok && int'(addr) == i)      tx_q[i] <= wdata;
        end
        assign tx_flat[i*8 +: 8] = tx_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            stretch_q <= 1'b0;
        end else if (wr_ok) begin
            if (int'(addr) == A_CNT)
                cnt_q <= (int'(wdata) > MAXB) ? CW'(MAXB) : CW'(wdata);
            if (int'(addr) == A_CTRL)
                stretch_q <= wdata[CTRL_STRETCH];
        end
    end

    // R2
    cnt_max_chk: assert property (@(posedge clk) disable iff (rst) int'(cnt_q) <= MAXB);
endmodule

// File: rtl/sse_rxbank.sv
module sse_rxbank
    import sse_pkg::*;
#(
    parameter int NBITS = RX_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [NBITS-1:0] rx_flat
);
    always_ff @(posedge clk) begin
        if (rst)           rx_flat <= '0;
        else if (shift_en) rx_flat <= {rx_flat[NBITS-2:0], bit_in};
    end

    // R8
    rx_entry_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> rx_flat[0] == $past(bit_in));
endmodule

// File: rtl/sse_shifter.sv
module sse_shifter
    import sse_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int TXB      = TX_BITS,
    parameter int CW       = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CW-1:0]  nbits,
    input  logic [TXB-1:0] tx_flat,
    input  logic           miso,
    output spi_pins_t      pins,
    output logic           busy,
    output logic           done,
    output logic           rx_shift,
    output logic           rx_bit
);
    localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    sh_state_e       state;
    logic [PH_W-1:0] ph;
    logic [CW-1:0]   bidx;
    logic [CW-1:0]   last;

    assign busy = (state == SH_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            pins     <= '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0};
            ph       <= '0;
            bidx     <= '0;
            last     <= '0;
            done     <= 1'b0;
            rx_shift <= 1'b0;
            rx_bit   <= 1'b0;
        end else begin
            done     <= 1'b0;
            rx_shift <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        if (nbits == '0) begin
                            done <= 1'b1;
                        end else begin
                            state     <= SH_RUN;
                            pins.cs_n <= 1'b0;
                            pins.sck  <= 1'b0;
                            pins.mosi <= stream_bit(tx_flat, '0);
                            ph        <= '0;
                            bidx      <= '0;
                            last      <= nbits - 1'b1;
                        end
                    end
                end
                SH_RUN: begin
                    if (int'(ph) == HALF_DIV - 1) begin
                        ph <= '0;
                        if (!pins.sck) begin
                            pins.sck <= 1'b1;
                            rx_shift <= 1'b1;
                            rx_bit   <= miso;
                        end else begin
                            pins.sck <= 1'b0;
                            if (bidx == last) begin
                                state     <= SH_IDLE;
                                pins.cs_n <= 1'b1;
                                pins.mosi <= 1'b0;
                                done      <= 1'b1;
                            end else begin
                                bidx      <= bidx + 1'b1;
                                pins.mosi <= stream_bit(tx_flat, bidx + 1'b1);
                            end
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // R6
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst) pins.cs_n |-> !pins.sck);
    // R3
    cs_busy_chk: assert property (@(posedge clk) disable iff (rst) !pins.cs_n |-> busy);
    // R3
    end_done_chk: assert property (@(posedge clk) disable iff (rst)
        (pins.cs_n && !$past(pins.cs_n)) |-> done);
    // R11
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pins.sck && $past(pins.sck)) |-> $stable(pins.mosi));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import sse_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              busy,
    output logic              done,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic [TX_BITS-1:0] tx_flat;
    logic [RX_BITS-1:0] rx_flat;
    logic [CNT_W-1:0]   cnt_q;
    logic               stretch_q;
    logic               wr_ok;
    logic               start;
    logic [CNT_W-1:0]   nbits;
    logic               rx_shift;
    logic               rx_bit;
    spi_pins_t          pins;

    assign wr_ok = reg_we && !busy;
    assign start = wr_ok && (int'(reg_addr) == A_CTRL) && reg_wdata[CTRL_START];
    assign nbits = (cnt_q == '0) ? '0 : cnt_q + CNT_W'(reg_wdata[CTRL_STRETCH]);

    sse_regbank #(.NTX(TX_BYTES), .MAXB(MAX_BITS), .CW(CNT_W)) regs_i (
        .clk, .rst, .wr_ok, .addr(reg_addr), .wdata(reg_wdata),
        .tx_flat, .cnt_q, .stretch_q
    );

    sse_shifter #(.HALF_DIV(HALF_DIV), .TXB(TX_BITS), .CW(CNT_W)) shift_i (
        .clk, .rst, .start, .nbits, .tx_flat, .miso(spi_miso),
        .pins, .busy, .done, .rx_shift, .rx_bit
    );

    sse_rxbank #(.NBITS(RX_BITS)) rx_i (
        .clk, .rst, .shift_en(rx_shift), .bit_in(rx_bit), .rx_flat
    );

    assign spi_sck  = pins.sck;
    assign spi_cs_n = pins.cs_n;
    assign spi_mosi = pins.mosi;

    always_comb begin
        int a;
        a = int'(reg_addr);
        reg_rdata = '0;
        if (a < TX_BYTES)
            reg_rdata = tx_flat[a*8 +: 8];
        else if (a == A_CNT)
            reg_rdata = 8'(cnt_q);
        else if (a == A_CTRL) begin
            reg_rdata[CTRL_START]   = busy;
            reg_rdata[CTRL_STRETCH] = stretch_q;
        end else if (a >= A_RX0 && a < A_RX0 + RX_BYTES)
            reg_rdata = rx_flat[(a-A_RX0)*8 +: 8];
    end

    // R10
    busy_nostart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we) |=> busy || done);
endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb_top;
    import sse_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HD         = 2;

    typedef struct packed {
        logic [47:0] tx;
        logic [7:0]  cnt;
        logic        st;
        logic [63:0] pat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{tx: 48'hA53C0FF0817E, cnt: 8'd48, st: 1'b0, pat: 64'hDEADBEEF01234567},
        '{tx: 48'h9F0000000000, cnt: 8'd8,  st: 1'b0, pat: 64'hC3A5000000000000},
        '{tx: 48'h03123456FFFF, cnt: 8'd56, st: 1'b0, pat: 64'h0123456789ABCDEF},
        '{tx: 48'h0BAA55001122, cnt: 8'd40, st: 1'b1, pat: 64'hF0F00FF0A55A3CC3},
        '{tx: 48'h5AC3E1000000, cnt: 8'd13, st: 1'b1, pat: 64'hB6D9000000000000},
        '{tx: 48'hFFFFFFFFFFFF, cnt: 8'd70, st: 1'b1, pat: 64'h8001800180018001},
        '{tx: 48'h123456789ABC, cnt: 8'd0,  st: 1'b1, pat: 64'hFFFFFFFFFFFFFFFF},
        '{tx: 48'h800000000001, cnt: 8'd1,  st: 1'b0, pat: 64'h8000000000000000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              busy, done, spi_sck, spi_cs_n, spi_mosi;
    logic              spi_miso;

    int          n_chk = 0;
    int          n_bad = 0;
    int          nrise = 0;
    int          nfall = 0;
    int          base_f = 0;
    logic [63:0] mon = '0;
    logic [63:0] cur_pat = '0;
    logic [79:0] rx_m = '0;
    logic [5:0]  pidx;

    spi_shift_engine #(.HALF_DIV(HD)) dut_i (
        .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .busy, .done, .spi_sck, .spi_cs_n, .spi_mosi, .spi_miso
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge spi_sck) begin
        mon   <= {mon[62:0], spi_mosi};
        nrise <= nrise + 1;
    end
    always @(negedge spi_sck) nfall <= nfall + 1;

    assign pidx     = 6'(nfall - base_f);
    assign spi_miso = cur_pat[~pidx];

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        reg_addr = ADDR_W'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic check_rx(input string req);
        logic [7:0] v;
        for (int j = 0; j < RX_BYTES; j++) begin
            rd(A_RX0 + j, v);
            check(v == rx_m[j*8 +: 8], req, 80'(v), 80'(rx_m[j*8 +: 8]));
        end
    endtask

    task automatic run_vec(input vec_t v);
        int          stored, eff, lowc, r0, guard;
        logic [63:0] exp, mask;
        logic [7:0]  rv;
        stored = (int'(v.cnt) > 56) ? 56 : int'(v.cnt);
        eff    = (stored == 0) ? 0 : stored + int'(v.st);
        for (int i = 0; i < TX_BYTES; i++) wr(i, v.tx[i*8 +: 8]);
        wr(A_CNT, v.cnt);
        rd(A_CNT, rv);
        // R2 clamp and readback
        check(int'(rv) == stored, "R2", 80'(rv), 80'(stored));
        cur_pat = v.pat;
        base_f  = nfall;
        r0      = nrise;
        wr(A_CTRL, 8'h04 | (8'(v.st) << 4));
        if (eff > 0) begin
            rd(A_CTRL, rv);
            // R3 start bit visible while running
            check(rv[2] == 1'b1 && !spi_cs_n && busy, "R3", 80'({rv[2], spi_cs_n, busy}), 80'(3'b101));
        end else begin
            // R9 zero count completes at once
            check(done && spi_cs_n && !busy, "R9", 80'({done, spi_cs_n, busy}), 80'(3'b110));
        end
        lowc = 0; guard = 0;
        while (busy && guard < 2000) begin
            if (!spi_cs_n) lowc++;
            guard++;
            @(negedge clk);
        end
        rd(A_CTRL, rv);
        // R3 done pulse and start bit cleared
        check(done && rv[2] == 1'b0 && spi_cs_n, "R3", 80'({done, rv[2], spi_cs_n}), 80'(3'b101));
        // R6 / R7 pulse count
        check(nrise - r0 == eff, v.st ? "R7" : "R6", 80'(nrise - r0), 80'(eff));
        // R6 chip select low time
        check(lowc == eff * 2 * HD, "R6", 80'(lowc), 80'(eff * 2 * HD));
        exp = '0;
        for (int k = 0; k < eff; k++)
            exp = {exp[62:0], (k < 48) ? v.tx[47-k] : 1'b0};
        mask = (eff == 0) ? 64'd0 : ((64'd1 << eff) - 64'd1);
        // R4 / R5 outgoing stream
        check((mon & mask) == exp, (eff > 48) ? "R5" : "R4", 80'(mon & mask), 80'(exp));
        for (int k = 0; k < eff; k++) rx_m = {rx_m[78:0], v.pat[63-k]};
        check_rx("R8");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int         r0, lowc, guard;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n && !spi_sck && !spi_mosi && !busy, "R1",
              80'({spi_cs_n, spi_sck, spi_mosi, busy}), 80'(4'b1000));
        for (int a = 0; a < A_RX0 + RX_BYTES; a++) begin
            rd(a, v);
            check(v == 8'h00, "R1", 80'(v), 80'h0);
        end

        for (int n = 0; n < NV; n++) run_vec(VECS[n]);

        // R10: writes during an active transfer are ignored
        for (int i = 0; i < TX_BYTES; i++) wr(i, 8'(8'h31 + i));
        wr(A_CNT, 8'd16);
        wr(A_CTRL, 8'h00);
        cur_pat = 64'h6BD2000000000000;
        base_f  = nfall;
        r0      = nrise;
        wr(A_CTRL, 8'h04);
        repeat (5) @(negedge clk);
        wr(5, 8'h77);
        wr(A_CTRL, 8'h14);
        rd(5, v);
        check(v == 8'h36, "R10", 80'(v), 80'h36);
        guard = 0;
        while (busy && guard < 2000) begin guard++; @(negedge clk); end
        check(nrise - r0 == 16, "R10", 80'(nrise - r0), 80'd16);
        check(mon[15:0] == 16'h3635, "R10", 80'(mon[15:0]), 80'h3635);
        rd(A_CTRL, v);
        check(v[4] == 1'b0, "R10", 80'(v[4]), 80'h0);
        for (int k = 0; k < 16; k++) rx_m = {rx_m[78:0], cur_pat[63-k]};
        r0 = nrise; lowc = 0;
        repeat (20) begin
            @(negedge clk);
            if (busy || !spi_cs_n) lowc++;
        end
        check(lowc == 0 && nrise == r0, "R10", 80'(lowc), 80'h0);
        check_rx("R8");

        // R9 zero count with stretch leaves no SCK edge
        wr(A_CNT, 8'd0);
        r0 = nrise;
        wr(A_CTRL, 8'h14);
        check(done && spi_cs_n, "R9", 80'({done, spi_cs_n}), 80'(2'b11));
        repeat (4) @(negedge clk);
        check(nrise == r0 && !busy, "R9", 80'(nrise - r0), 80'h0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule